// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver

This block moves 18-bit words between two buses, called A and B, in either direction. Each direction has its own storage element. That element runs as a transparent pass-through while its latch enable is high. While the latch enable is low, it runs as a holding latch, and it becomes an edge-triggered register when its data clock rises. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low.

The model is fully synchronous. A fast system clock samples the latch-enable and data-clock inputs of both directions. A data-clock rising edge is found by comparing the present data-clock level with its level at the previous system edge. Each port delivers a drive-data vector and a one-bit drive enable, so a tri-state pad wrapper at chip level can form the pins. On the input side, each port has a per-bit "externally driven" mask and a bus keeper. An undriven bit keeps the last level seen on it. A port that is driving never reads back its own driven value.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst` is high, `a_oe` and `b_oe` are both 0. After reset, both storage elements hold zero.
- R2: While `ab_le` is 1, `b_out` equals the A-port input value (after the keeper) in the same cycle, with no register in the path.
- R3: While `ab_le` is 0, `b_out` does not change when A changes, provided `ab_clk` stays at a constant level. This holds with the clock steady high and with it steady low.
- R4: While `ab_le` is 0, a sampled `ab_clk` change from 0 to 1 between two system edges loads the A value into the A-to-B element at the second edge. A change from 1 to 0 loads nothing.
- R5: `b_oe` is 1 exactly when `ab_oe` is 1, outside reset (active high).
- R6: `a_oe` is 1 exactly when `ba_oen` is 0, outside reset (active low).
- R7: The B-to-A path behaves like R2 to R4, using `ba_le` and `ba_clk`, from the B input to `a_out`.
- R8: A bit whose `*_ext_en` bit is 0 takes, as its input value, the level it had at the last system edge.
- R9: While a port's drive enable is 1, that port's input value is frozen at its level from before driving started. When driving stops, the external value is used again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_ext | input | 18 | Level seen on the A bus |
| a_ext_en | input | 18 | Per-bit flag: A bus bit has an external driver |
| b_ext | input | 18 | Level seen on the B bus |
| b_ext_en | input | 18 | Per-bit flag: B bus bit has an external driver |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_clk | input | 1 | A-to-B data clock, captures on rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_clk | input | 1 | B-to-A data clock, captures on rising edge |
| ba_oen | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | Drive data for the A pads |
| a_oe | output | 1 | Drive enable for the A pads |
| b_out | output | 18 | Drive data for the B pads |
| b_oe | output | 1 | Drive enable for the B pads |

## Verification
The A-to-B path is exercised with several contrasting words: alternating bits, their complement, and a nibble pattern.

- In transparent mode, these words separate a combinational pass-through from a one-cycle registered copy.
- In hold mode, each word is tried with the data clock parked high and with it parked low. This separates a true hold from a level-sensitive capture.
- In capture mode, the output is sampled both before and after the system edge that follows a data-clock rise. This pins the load to that edge, and a later fall must leave the word alone.

Partial release masks on the input show that only the released bits keep their old level. Turning on a port's own driver shows that the input is frozen rather than read back.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
   parameter int unsigned UBT_W = 18;

   typedef enum logic [1:0] {
      MODE_HOLD    = 2'd0,
      MODE_PASS    = 2'd1,
      MODE_CAPTURE = 2'd2
   } ubt_mode_e;
endpackage

// File: rtl/ubt_rise_det.sv
module ubt_rise_det (
   input  logic clk,
   input  logic lvl,
   output logic rise
);
   logic lvl_q;

   // tracks the level every cycle, also in reset, so reset release
   // never shows a false edge
   always_ff @(posedge clk) begin
      lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ubt_keeper.sv
module ubt_keeper #(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ext,
   input  logic [W-1:0] ext_en,
   input  logic         own_drive,
   output logic [W-1:0] kept,
   output logic [W-1:0] held
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign kept[i] = (ext_en[i] && !own_drive) ? ext[i] : held[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) held <= '0;
      else     held <= kept;
   end
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
   import ubt_pkg::*;
#(
   parameter int unsigned W             = 18,
   parameter bit          OE_ACTIVE_LOW = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   input  logic         le,
   input  logic         dclk,
   input  logic         oe_in,
   output logic [W-1:0] dout,
   output logic         drive,
   output logic [W-1:0] q
);
   logic      rise;
   ubt_mode_e mode;

   ubt_rise_det edge_i (
      .clk  (clk),
      .lvl  (dclk),
      .rise (rise)
   );

   always_comb begin
      if (le)        mode = MODE_PASS;
      else if (rise) mode = MODE_CAPTURE;
      else           mode = MODE_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         case (mode)
            MODE_PASS, MODE_CAPTURE: q <= din;
            default:                 q <= q;
         endcase
      end
   end

   assign dout = le ? din : q;

   generate
      if (OE_ACTIVE_LOW) begin : g_oe_low
         assign drive = !rst && !oe_in;
      end else begin : g_oe_high
         assign drive = !rst && oe_in;
      end
   endgenerate
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
   parameter int unsigned W = ubt_pkg::UBT_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_ext,
   input  logic [W-1:0] a_ext_en,
   input  logic [W-1:0] b_ext,
   input  logic [W-1:0] b_ext_en,
   input  logic         ab_le,
   input  logic         ab_clk,
   input  logic         ab_oe,
   input  logic         ba_le,
   input  logic         ba_clk,
   input  logic         ba_oen,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   generate
      if (W < 1) begin : g_bad_width
         $error("ubt_xcvr: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] a_kept, a_held, b_kept, b_held;
   logic [W-1:0] ab_q, ba_q;

   ubt_keeper #(.W(W)) a_keep_i (
      .clk(clk), .rst(rst), .ext(a_ext), .ext_en(a_ext_en),
      .own_drive(a_oe), .kept(a_kept), .held(a_held)
   );

   ubt_keeper #(.W(W)) b_keep_i (
      .clk(clk), .rst(rst), .ext(b_ext), .ext_en(b_ext_en),
      .own_drive(b_oe), .kept(b_kept), .held(b_held)
   );

   ubt_lane #(.W(W), .OE_ACTIVE_LOW(1'b0)) ab_lane_i (
      .clk(clk), .rst(rst), .din(a_kept), .le(ab_le), .dclk(ab_clk),
      .oe_in(ab_oe), .dout(b_out), .drive(b_oe), .q(ab_q)
   );

   ubt_lane #(.W(W), .OE_ACTIVE_LOW(1'b1)) ba_lane_i (
      .clk(clk), .rst(rst), .din(b_kept), .le(ba_le), .dclk(ba_clk),
      .oe_in(ba_oen), .dout(a_out), .drive(a_oe), .q(ba_q)
   );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
   parameter int unsigned W = 18
) (
   input logic         clk,
   input logic         rst,
   input logic         ab_le,
   input logic         ab_clk,
   input logic         ba_le,
   input logic         ba_clk,
   input logic         a_oe,
   input logic         b_oe,
   input logic [W-1:0] a_kept,
   input logic [W-1:0] b_kept,
   input logic [W-1:0] a_held,
   input logic [W-1:0] ab_q,
   input logic [W-1:0] ba_q
);
   assert_quiet_in_reset_R1: assert property (@(posedge clk)
      rst |-> (!a_oe && !b_oe));

   assert_cleared_after_reset_R1: assert property (@(posedge clk)
      rst |=> (ab_q == '0 && ba_q == '0));

   assert_pass_loads_R2: assert property (@(posedge clk) disable iff (rst)
      ab_le |=> (ab_q == $past(a_kept)));

   assert_static_clk_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (!ab_le && !(ab_clk && !$past(ab_clk))) |=> (ab_q == $past(ab_q)));

   assert_rise_captures_R4: assert property (@(posedge clk) disable iff (rst)
      (!ab_le && ab_clk && !$past(ab_clk)) |=> (ab_q == $past(a_kept)));

   assert_ba_static_holds_R7: assert property (@(posedge clk) disable iff (rst)
      (!ba_le && !(ba_clk && !$past(ba_clk))) |=> (ba_q == $past(ba_q)));

   assert_ba_rise_captures_R7: assert property (@(posedge clk) disable iff (rst)
      (!ba_le && ba_clk && !$past(ba_clk)) |=> (ba_q == $past(b_kept)));

   assert_no_readback_R9: assert property (@(posedge clk) disable iff (rst)
      a_oe |=> (a_held == $past(a_held)));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) chk_i (
   .clk(clk), .rst(rst), .ab_le(ab_le), .ab_clk(ab_clk),
   .ba_le(ba_le), .ba_clk(ba_clk), .a_oe(a_oe), .b_oe(b_oe),
   .a_kept(a_kept), .b_kept(b_kept), .a_held(a_held),
   .ab_q(ab_q), .ba_q(ba_q)
);

// File: tb/ubt_xcvr_tb_top.sv
`timescale 1ns/1ps
module ubt_xcvr_tb_top;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] a_ext, a_ext_en, b_ext, b_ext_en;
   logic         ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oen;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ubt_xcvr #(.W(W)) dut_i (
      .clk(clk), .rst(rst), .a_ext(a_ext), .a_ext_en(a_ext_en),
      .b_ext(b_ext), .b_ext_en(b_ext_en), .ab_le(ab_le), .ab_clk(ab_clk),
      .ab_oe(ab_oe), .ba_le(ba_le), .ba_clk(ba_clk), .ba_oen(ba_oen),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic to_neg();
      @(negedge clk);
   endtask

   task automatic after_pos();
      @(posedge clk);
      #2;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      ab_oe = 1'b1; ba_oen = 1'b0;
      after_pos();
      after_pos();
      chk("R1 a_oe in reset", W'(a_oe), W'(0));
      chk("R1 b_oe in reset", W'(b_oe), W'(0));
      to_neg();
      rst = 1'b0;
      #2;
      chk("R1 b_out zero after reset", b_out, '0);
      chk("R1 a_out zero after reset", a_out, '0);
      to_neg();
      ba_oen = 1'b1;
   endtask

   task automatic t_transparent();
      logic [W-1:0] pats [3] = '{18'h2AAAA, 18'h15555, 18'h0F0F0};
      to_neg();
      ab_le = 1'b1;
      foreach (pats[i]) begin
         to_neg();
         a_ext = pats[i];
         #2;
         chk("R2 transparent same cycle", b_out, pats[i]);
      end
   endtask

   task automatic t_hold();
      to_neg();
      a_ext = 18'h2AAAA;
      after_pos();
      to_neg();
      ab_le = 1'b0;
      ab_clk = 1'b1;
      after_pos();
      to_neg();
      a_ext = 18'h15555;
      repeat (3) after_pos();
      chk("R3 hold clock high", b_out, 18'h2AAAA);
      to_neg();
      ab_clk = 1'b0;
      repeat (3) after_pos();
      chk("R4 fall does not load", b_out, 18'h2AAAA);
      to_neg();
      a_ext = 18'h0F0F0;
      repeat (2) after_pos();
      chk("R3 hold clock low", b_out, 18'h2AAAA);
   endtask

   task automatic t_capture();
      to_neg();
      a_ext = 18'h3C3C3;
      to_neg();
      ab_clk = 1'b1;
      #2;
      chk("R4 no load before edge", b_out, 18'h2AAAA);
      after_pos();
      chk("R4 rise loads", b_out, 18'h3C3C3);
      to_neg();
      a_ext = 18'h00001;
      repeat (2) after_pos();
      chk("R4 single load per rise", b_out, 18'h3C3C3);
      to_neg();
      ab_clk = 1'b0;
   endtask

   task automatic t_oe();
      to_neg();
      ab_oe = 1'b0; #2;
      chk("R5 ab_oe low", W'(b_oe), W'(0));
      ab_oe = 1'b1; #2;
      chk("R5 ab_oe high", W'(b_oe), W'(1));
      ba_oen = 1'b1; #2;
      chk("R6 ba_oen high", W'(a_oe), W'(0));
      ba_oen = 1'b0; #2;
      chk("R6 ba_oen low", W'(a_oe), W'(1));
      ba_oen = 1'b1;
   endtask

   task automatic t_ba();
      to_neg();
      ab_oe = 1'b0; ba_oen = 1'b0;
      ba_le = 1'b1;
      b_ext = 18'h1E1E1; #2;
      chk("R7 ba transparent", a_out, 18'h1E1E1);
      after_pos();
      to_neg();
      ba_le = 1'b0;
      b_ext = 18'h00ABC;
      repeat (2) after_pos();
      chk("R7 ba hold", a_out, 18'h1E1E1);
      to_neg();
      ba_clk = 1'b1; #2;
      chk("R7 ba no load before edge", a_out, 18'h1E1E1);
      after_pos();
      chk("R7 ba rise loads", a_out, 18'h00ABC);
      to_neg();
      ba_clk = 1'b0; ab_oe = 1'b1; ba_oen = 1'b1;
   endtask

   task automatic t_keeper();
      to_neg();
      ab_le = 1'b1;
      a_ext = 18'h3C3C3;
      after_pos();
      to_neg();
      a_ext_en = 18'h000FF;
      a_ext = 18'h00000; #2;
      chk("R8 released bits keep level", b_out, 18'h3C300);
      repeat (3) after_pos();
      chk("R8 keeper retains", b_out, 18'h3C300);
      to_neg();
      a_ext_en = '1; #2;
      chk("R8 driven again follows bus", b_out, 18'h00000);
   endtask

   task automatic t_readback();
      to_neg();
      ab_le = 1'b1; ba_oen = 1'b1;
      a_ext = 18'h12345;
      after_pos();
      to_neg();
      ba_oen = 1'b0;
      a_ext = 18'h00FFF; #2;
      chk("R9 own drive not read", b_out, 18'h12345);
      repeat (2) after_pos();
      chk("R9 frozen while driving", b_out, 18'h12345);
      to_neg();
      ba_oen = 1'b1; #2;
      chk("R9 external used after drive", b_out, 18'h00FFF);
   endtask

   initial begin
      a_ext = '0; b_ext = '0; a_ext_en = '1; b_ext_en = '1;
      ab_le = 1'b0; ab_clk = 1'b0; ba_le = 1'b0; ba_clk = 1'b0;
      ab_oe = 1'b0; ba_oen = 1'b1; rst = 1'b1;
      t_reset();
      t_transparent();
      t_hold();
      t_capture();
      t_oe();
      t_ba();
      t_keeper();
      t_readback();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule